// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a parameterised set of event counters that software programs through a small word-addressed register port. Each counter is set up through its own type register. That register chooses one line of an event input vector and says which privilege levels may advance the counter. Software sets the enable bits and the overflow-interrupt enable bits with a write-one-to-set address and removes them with a write-one-to-clear address. The counters themselves cannot be addressed directly. Software first writes an index into a selector. It then reaches that counter's value and type through shared indirect addresses.

When a counter wraps, it raises a sticky overflow flag. The flags are read and cleared through one address. Any flag whose interrupt enable is set drives the single interrupt line. A global control word has four jobs: it enables the whole unit, it zeroes every counter with a one-shot bit, it chooses whether overflow happens at 32 or at 64 bits, and it reports the counter count and two identification bytes. At reset every register is zero. Software should still clear both enable masks before it sets the global enable.

Top module: `event_counter_bank`

## Requirements
- R1: After reset, the control word reads {IMPL_CODE[31:24], ID_CODE[23:16], NUM_CTR[15:8], 0[7:3], long[2], 0[1], enable[0]} with enable and long both 0. The enable masks, the overflow flags, the selector and every counter read 0, and irq is 0.
- R2: A write to address 1 sets the counter-enable bit of each position written as 1. A write to address 2 clears the bit of each position written as 1. Positions written as 0 keep their value. Both addresses read back the enable mask.
- R3: The interrupt-enable mask works the same way: address 3 sets bits and address 4 clears them, and both read back the mask.
- R4: A write to the selector (address 6) with a value below NUM_CTR stores it. A value of NUM_CTR or more leaves the selector unchanged. Addresses 7, 8 and 9 read and write the low value word, the high value word and the type of the selected counter.
- R5: A counter advances by one on each clock edge at which all of these hold: its selected event line is 1, global enable (control bit 0) is 1, its enable bit is 1, and the filter passes the current privilege level. If any one of these is 0, the counter holds its value.
- R6: The type register has three filter bits. Bit 31 set excludes user level (priv 0). Bit 30 set excludes kernel level (priv 1). Bit 29 set includes hypervisor level (priv 2). Priv 3 never counts.
- R7: With control bit 2 at 0, an increment from a low word of all ones sets the low word to 0 and leaves the high word alone. The same edge sets that counter's overflow flag.
- R8: With control bit 2 at 1, the 64-bit value carries from the low word into the high word without setting a flag. The flag is set only when the value wraps from all ones to 0.
- R9: Address 5 reads the overflow flags, and writing 1 to bit i clears flag i. If a wrap and a clear of the same flag fall on one edge, the flag stays set.
- R10: irq is 1 exactly when some counter has both its overflow flag and its interrupt enable set.
- R11: Writing control bit 1 as 1 zeroes every counter on that edge. The bit always reads back as 0.
- R12: The type register stores only the event-number field [EVW-1:0] and bits 31..29. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| evt_in | input | NUM_EVT | Event input lines |
| priv | input | 2 | Current privilege level: 0 user, 1 kernel, 2 hypervisor |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is a wrap and a software clear of the same overflow flag on one clock edge. In 64-bit mode the counter must be preloaded to all ones, then the event pulse and the clear write are driven in the same cycle. Wraps in both modes are reached the same way: the bench preloads values through the indirect value words rather than counting up to them. The filter and event-select sweeps run the small default configuration exhaustively. They cover every filter combination against every privilege level, and every event line against every type setting on every counter.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

  localparam int ADDR_W = 4;

  // register word addresses
  localparam logic [3:0] A_CTRL    = 4'd0;
  localparam logic [3:0] A_CEN_SET = 4'd1;
  localparam logic [3:0] A_CEN_CLR = 4'd2;
  localparam logic [3:0] A_IEN_SET = 4'd3;
  localparam logic [3:0] A_IEN_CLR = 4'd4;
  localparam logic [3:0] A_OVF     = 4'd5;
  localparam logic [3:0] A_SEL     = 4'd6;
  localparam logic [3:0] A_VAL_LO  = 4'd7;
  localparam logic [3:0] A_VAL_HI  = 4'd8;
  localparam logic [3:0] A_TYPE    = 4'd9;

  // control bits
  localparam int CB_EN   = 0;
  localparam int CB_ZERO = 1;
  localparam int CB_LONG = 2;

  // type filter bits
  localparam int TB_XUSER = 31;
  localparam int TB_XKERN = 30;
  localparam int TB_IHYP  = 29;

  typedef enum logic [1:0] {
    PL_USER = 2'd0,
    PL_KERN = 2'd1,
    PL_HYP  = 2'd2,
    PL_RSVD = 2'd3
  } priv_e;

  // privilege filter decision
  function automatic logic level_allowed(input logic [31:0] typ, input logic [1:0] pl);
    case (priv_e'(pl))
      PL_USER: return !typ[TB_XUSER];
      PL_KERN: return !typ[TB_XKERN];
      PL_HYP:  return typ[TB_IHYP];
      default: return 1'b0;
    endcase
  endfunction

  // next counter value with wrap indication in bit 64
  function automatic logic [64:0] bump(input logic [63:0] v, input logic long_m);
    logic [32:0] lo;
    logic [64:0] full;
    lo   = {1'b0, v[31:0]} + 33'd1;
    full = {1'b0, v} + 65'd1;
    if (long_m) return full;
    return {lo[32], v[63:32], lo[31:0]};
  endfunction

endpackage

// File: rtl/ecb_counter.sv
module ecb_counter
  import ecb_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [1:0]         priv,
  input  logic               glob_en,
  input  logic               ctr_en,
  input  logic               long_mode,
  input  logic               zero_all,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               wr_type,
  input  logic [31:0]        wr_data,
  output logic [63:0]        value,
  output logic [31:0]        typ,
  output logic               wrap
);

  localparam int EVW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [31:0] TYPE_MASK = {3'b111, 29'd0} | 32'((64'd1 << EVW) - 64'd1);

  logic [EVW-1:0] evt_idx;
  logic           evt_hit;
  logic           count_now;
  logic [64:0]    stepped;

  assign evt_idx   = typ[EVW-1:0];
  assign evt_hit   = (int'(evt_idx) < NUM_EVT) ? evt_in[evt_idx] : 1'b0;
  assign count_now = glob_en & ctr_en & evt_hit & level_allowed(typ, priv);
  assign stepped   = bump(value, long_mode);
  assign wrap      = count_now & stepped[64] & ~zero_all & ~wr_lo & ~wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (zero_all) begin
      value <= '0;
    end else if (wr_lo) begin
      value[31:0] <= wr_data;
    end else if (wr_hi) begin
      value[63:32] <= wr_data;
    end else if (count_now) begin
      value <= stepped[63:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       typ <= '0;
    else if (wr_type) typ <= wr_data & TYPE_MASK;
  end

endmodule

// File: rtl/ecb_ovf.sv
module ecb_ovf #(
  parameter int NUM_CTR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] wrap_vec,
  input  logic               clr_we,
  input  logic [NUM_CTR-1:0] clr_mask,
  input  logic [NUM_CTR-1:0] int_en,
  output logic [NUM_CTR-1:0] flags,
  output logic               irq
);

  logic [NUM_CTR-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | wrap_vec;
  end

  assign irq = |(flags & int_en);

endmodule

// File: rtl/ecb_regs.sv
module ecb_regs
  import ecb_pkg::*;
#(
  parameter int         NUM_CTR   = 4,
  parameter int         SEL_W     = 2,
  parameter logic [7:0] ID_CODE   = 8'h5A,
  parameter logic [7:0] IMPL_CODE = 8'hC3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wr_data,
  input  logic [NUM_CTR-1:0]    ovf_flags,
  input  logic [NUM_CTR*64-1:0] cnt_flat,
  input  logic [NUM_CTR*32-1:0] type_flat,
  output logic [31:0]           rd_data,
  output logic                  glob_en,
  output logic                  long_mode,
  output logic                  zero_pulse,
  output logic [NUM_CTR-1:0]    cnt_en,
  output logic [NUM_CTR-1:0]    int_en,
  output logic [SEL_W-1:0]      sel_q,
  output logic                  wr_lo,
  output logic                  wr_hi,
  output logic                  wr_type,
  output logic                  ovf_clr_we
);

  logic w_ctrl, w_cset, w_cclr, w_iset, w_iclr, w_sel;
  logic sel_ok;
  int   sel_idx;

  assign w_ctrl = wr_en && (addr == A_CTRL);
  assign w_cset = wr_en && (addr == A_CEN_SET);
  assign w_cclr = wr_en && (addr == A_CEN_CLR);
  assign w_iset = wr_en && (addr == A_IEN_SET);
  assign w_iclr = wr_en && (addr == A_IEN_CLR);
  assign w_sel  = wr_en && (addr == A_SEL);

  assign sel_idx = int'(sel_q);
  assign sel_ok  = sel_idx < NUM_CTR;

  assign zero_pulse = w_ctrl && wr_data[CB_ZERO];
  assign wr_lo      = wr_en && (addr == A_VAL_LO) && sel_ok;
  assign wr_hi      = wr_en && (addr == A_VAL_HI) && sel_ok;
  assign wr_type    = wr_en && (addr == A_TYPE)   && sel_ok;
  assign ovf_clr_we = wr_en && (addr == A_OVF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en   <= 1'b0;
      long_mode <= 1'b0;
    end else if (w_ctrl) begin
      glob_en   <= wr_data[CB_EN];
      long_mode <= wr_data[CB_LONG];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_en <= '0;
    else if (w_cset) cnt_en <= cnt_en | wr_data[NUM_CTR-1:0];
    else if (w_cclr) cnt_en <= cnt_en & ~wr_data[NUM_CTR-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      int_en <= '0;
    else if (w_iset) int_en <= int_en | wr_data[NUM_CTR-1:0];
    else if (w_iclr) int_en <= int_en & ~wr_data[NUM_CTR-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (w_sel && (wr_data < 32'(NUM_CTR))) sel_q <= wr_data[SEL_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL: rd_data = {IMPL_CODE, ID_CODE, 8'(NUM_CTR), 5'd0, long_mode, 1'b0, glob_en};
      A_CEN_SET, A_CEN_CLR: rd_data[NUM_CTR-1:0] = cnt_en;
      A_IEN_SET, A_IEN_CLR: rd_data[NUM_CTR-1:0] = int_en;
      A_OVF:    rd_data[NUM_CTR-1:0] = ovf_flags;
      A_SEL:    rd_data[SEL_W-1:0]   = sel_q;
      A_VAL_LO: if (sel_ok) rd_data = cnt_flat[sel_idx*64 +: 32];
      A_VAL_HI: if (sel_ok) rd_data = cnt_flat[sel_idx*64+32 +: 32];
      A_TYPE:   if (sel_ok) rd_data = type_flat[sel_idx*32 +: 32];
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/event_counter_bank.sv
module event_counter_bank
  import ecb_pkg::*;
#(
  parameter int         NUM_CTR   = 4,
  parameter int         NUM_EVT   = 8,
  parameter logic [7:0] ID_CODE   = 8'h5A,
  parameter logic [7:0] IMPL_CODE = 8'hC3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [1:0]         priv,
  output logic               irq
);

  localparam int SEL_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

  logic                  glob_en, long_mode, zero_pulse;
  logic [NUM_CTR-1:0]    cnt_en, int_en, ovf_flags, wrap_vec;
  logic [SEL_W-1:0]      sel_q;
  logic                  wr_lo, wr_hi, wr_type, ovf_clr_we;
  logic                  any_cnt_wr;
  logic [NUM_CTR*64-1:0] cnt_flat;
  logic [NUM_CTR*32-1:0] type_flat;

  assign any_cnt_wr = wr_lo | wr_hi;

  ecb_regs #(
    .NUM_CTR(NUM_CTR), .SEL_W(SEL_W), .ID_CODE(ID_CODE), .IMPL_CODE(IMPL_CODE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ovf_flags(ovf_flags), .cnt_flat(cnt_flat), .type_flat(type_flat),
    .rd_data(rd_data), .glob_en(glob_en), .long_mode(long_mode),
    .zero_pulse(zero_pulse), .cnt_en(cnt_en), .int_en(int_en), .sel_q(sel_q),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_type(wr_type), .ovf_clr_we(ovf_clr_we)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic hit_sel;
    assign hit_sel = (int'(sel_q) == i);
    ecb_counter #(.NUM_EVT(NUM_EVT)) u_ctr (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .priv(priv),
      .glob_en(glob_en), .ctr_en(cnt_en[i]), .long_mode(long_mode),
      .zero_all(zero_pulse), .wr_lo(wr_lo & hit_sel), .wr_hi(wr_hi & hit_sel),
      .wr_type(wr_type & hit_sel), .wr_data(wr_data),
      .value(cnt_flat[i*64 +: 64]), .typ(type_flat[i*32 +: 32]),
      .wrap(wrap_vec[i])
    );
  end

  ecb_ovf #(.NUM_CTR(NUM_CTR)) u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap_vec(wrap_vec), .clr_we(ovf_clr_we),
    .clr_mask(wr_data[NUM_CTR-1:0]), .int_en(int_en), .flags(ovf_flags),
    .irq(irq)
  );

endmodule

// File: rtl/ecb_checker.sv
module ecb_checker #(
  parameter int NUM_CTR = 4,
  parameter int SEL_W   = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  irq,
  input logic                  glob_en,
  input logic                  zero_pulse,
  input logic                  any_cnt_wr,
  input logic [SEL_W-1:0]      sel_q,
  input logic [NUM_CTR-1:0]    ovf_flags,
  input logic [NUM_CTR-1:0]    int_en,
  input logic [NUM_CTR-1:0]    wrap_vec,
  input logic [NUM_CTR*64-1:0] cnt_flat
);

  // R9
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_flags & ~$past(ovf_flags)) & ~$past(wrap_vec)) == '0);

  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flags != '0));

  // R10
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_en != '0));

  // R11
  zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |=> (cnt_flat == '0));

  // R5
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !any_cnt_wr && !zero_pulse) |=> $stable(cnt_flat));

  // R4
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) < NUM_CTR);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_wrap
    // R7
    wrap_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_vec[i] |=> (cnt_flat[i*64 +: 32] == 32'd0));
  end

endmodule

bind event_counter_bank ecb_checker #(.NUM_CTR(NUM_CTR), .SEL_W(SEL_W)) u_ecb_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .glob_en(glob_en),
  .zero_pulse(zero_pulse), .any_cnt_wr(any_cnt_wr), .sel_q(sel_q),
  .ovf_flags(ovf_flags), .int_en(int_en), .wrap_vec(wrap_vec),
  .cnt_flat(cnt_flat)
);

// File: tb/tb_event_counter_bank.sv
`timescale 1ns/1ps
module tb_event_counter_bank;

  localparam int NC = 4;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic [NE-1:0] evt_in = '0;
  logic [1:0]  priv = 2'd0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  event_counter_bank #(.NUM_CTR(NC), .NUM_EVT(NE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .priv(priv), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic tick(input logic [NE-1:0] e, input logic [1:0] pl);
    @(negedge clk);
    evt_in = e; priv = pl;
    @(negedge clk);
    evt_in = '0;
  endtask

  // bench's own statement of the privilege filter
  function automatic logic expect_count(input logic [2:0] f, input logic [1:0] pl);
    logic r;
    r = 1'b0;
    if (pl == 2'd0 && f[2] == 1'b0) r = 1'b1;
    if (pl == 2'd1 && f[1] == 1'b0) r = 1'b1;
    if (pl == 2'd2 && f[0] == 1'b1) r = 1'b1;
    return r;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); check("R1 ctrl", v, 32'hC35A0400);
    rd(4'd1, v); check("R1 cnt_en", v, 0);
    rd(4'd3, v); check("R1 int_en", v, 0);
    rd(4'd5, v); check("R1 ovf", v, 0);
    rd(4'd6, v); check("R1 sel", v, 0);
    rd(4'd7, v); check("R1 value", v, 0);
    check("R1 irq", irq, 0);

    // R2 counter enable set/clear
    wr(4'd1, 32'h5); rd(4'd1, v); check("R2 set", v, 32'h5);
    wr(4'd1, 32'h2); rd(4'd2, v); check("R2 set more", v, 32'h7);
    wr(4'd2, 32'h4); rd(4'd1, v); check("R2 clear", v, 32'h3);
    wr(4'd2, 32'h0); rd(4'd2, v); check("R2 zero no effect", v, 32'h3);
    wr(4'd1, 32'h0); rd(4'd1, v); check("R2 zero set no effect", v, 32'h3);

    // R3 interrupt enable set/clear
    wr(4'd3, 32'h9); rd(4'd3, v); check("R3 set", v, 32'h9);
    wr(4'd4, 32'h1); rd(4'd4, v); check("R3 clear", v, 32'h8);
    wr(4'd4, 32'h0); rd(4'd3, v); check("R3 zero no effect", v, 32'h8);
    wr(4'd4, 32'hF); rd(4'd3, v); check("R3 clear all", v, 32'h0);

    // R4 selector and indirect access
    wr(4'd6, 32'd2); rd(4'd6, v); check("R4 sel store", v, 2);
    wr(4'd6, 32'd4); rd(4'd6, v); check("R4 sel out of range", v, 2);
    wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, v); check("R4 sel huge", v, 2);
    wr(4'd7, 32'h1234);
    wr(4'd6, 32'd1); rd(4'd7, v); check("R4 other ctr", v, 0);
    wr(4'd6, 32'd2); rd(4'd7, v); check("R4 indirect value", v, 32'h1234);

    // R12 type masking
    wr(4'd6, 32'd0); wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, v); check("R12 type mask", v, 32'hE000_0007);

    // R5 event-select sweep over every counter and type
    wr(4'd1, 32'hF);
    for (int i = 0; i < NC; i++) begin
      for (int t = 0; t < NE; t++) begin
        wr(4'd6, i);
        wr(4'd9, t);
        wr(4'd0, 32'h3);
        for (int e = 0; e < NE; e++) tick(NE'(1 << e), 2'd0);
        rd(4'd7, v);
        check($sformatf("R5 select ctr%0d evt%0d", i, t), v, 1);
      end
    end

    // R5 gating by global and per-counter enable
    wr(4'd6, 32'd0); wr(4'd9, 32'd0);
    wr(4'd0, 32'h2); tick(8'h1, 2'd0);
    rd(4'd7, v); check("R5 global off", v, 0);
    wr(4'd0, 32'h1); wr(4'd2, 32'h1); tick(8'h1, 2'd0);
    rd(4'd7, v); check("R5 counter off", v, 0);
    wr(4'd1, 32'h1); tick(8'h1, 2'd0);
    rd(4'd7, v); check("R5 both on", v, 1);
    tick(8'h0, 2'd0);
    rd(4'd7, v); check("R5 no event", v, 1);

    // R6 filter sweep
    for (int f = 0; f < 8; f++) begin
      for (int pl = 0; pl < 4; pl++) begin
        wr(4'd9, 32'(f) << 29);
        wr(4'd0, 32'h3);
        tick(8'h1, 2'(pl));
        rd(4'd7, v);
        check($sformatf("R6 filter %0d priv %0d", f, pl), v,
              64'(expect_count(3'(f), 2'(pl))));
      end
    end

    // R7 short-mode wrap
    wr(4'd0, 32'h1);
    wr(4'd6, 32'd1); wr(4'd9, 32'd1);
    wr(4'd8, 32'hAB); wr(4'd7, 32'hFFFF_FFFE);
    tick(8'h2, 2'd0);
    rd(4'd5, v); check("R7 no flag yet", v, 0);
    tick(8'h2, 2'd0);
    rd(4'd7, v); check("R7 low wrapped", v, 0);
    rd(4'd8, h); check("R7 high kept", h, 32'hAB);
    rd(4'd5, v); check("R7 flag", v, 32'h2);

    // R8 long-mode carry and wrap
    wr(4'd0, 32'h5);
    wr(4'd6, 32'd2); wr(4'd9, 32'd2);
    wr(4'd8, 32'h0); wr(4'd7, 32'hFFFF_FFFF);
    tick(8'h4, 2'd0);
    rd(4'd7, v); check("R8 carry low", v, 0);
    rd(4'd8, h); check("R8 carry high", h, 1);
    rd(4'd5, v); check("R8 no flag on carry", v, 32'h2);
    wr(4'd8, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    tick(8'h4, 2'd0);
    rd(4'd8, h); check("R8 wrap high", h, 0);
    rd(4'd5, v); check("R8 flag", v, 32'h6);

    // R9 flag clear
    wr(4'd5, 32'h2); rd(4'd5, v); check("R9 clear one", v, 32'h4);
    wr(4'd5, 32'h0); rd(4'd5, v); check("R9 zero no effect", v, 32'h4);
    wr(4'd5, 32'h4); rd(4'd5, v); check("R9 clear all", v, 0);
    wr(4'd8, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd5; wr_data = 32'h4; evt_in = 8'h4; priv = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; evt_in = '0;
    rd(4'd5, v); check("R9 set wins over clear", v, 32'h4);

    // R10 interrupt combine
    check("R10 no enable", irq, 0);
    wr(4'd3, 32'h2); check("R10 other enable", irq, 0);
    wr(4'd3, 32'h4); check("R10 asserted", irq, 1);
    wr(4'd4, 32'h4); check("R10 enable cleared", irq, 0);
    wr(4'd3, 32'h4); wr(4'd5, 32'h4); check("R10 flag cleared", irq, 0);

    // R11 zero all counters
    wr(4'd6, 32'd3); wr(4'd7, 32'h77);
    wr(4'd0, 32'h3);
    for (int i = 0; i < NC; i++) begin
      wr(4'd6, i);
      rd(4'd7, v); rd(4'd8, h);
      check($sformatf("R11 ctr%0d zero", i), {h, v}, 0);
    end
    rd(4'd0, v); check("R11 bit reads zero", v, 32'hC35A0401);

    done = 1;
    finish_run();
  end

endmodule